// File: doc/BRIEF.md
# Serial 1101 Pattern Detector

This block watches a one-bit serial stream, taking one bit per clock, and flags each point where the stream completes the pattern 1101. It is a four-state Mealy machine. The flag is formed from the current state and the bit on the input in the same cycle. There is no register on the output, so the flag rises in the cycle that carries the final 1 of the pattern. Occurrences may overlap: the trailing 1 of one match can serve as the leading 1 of the next.

The two-bit state register uses a fixed Gray-coded assignment:

| State | Code | Meaning |
| --- | --- | --- |
| Idle | 00 | Last bit was 0 (also the reset state) |
| One | 01 | A fresh 1 |
| Two | 11 | 11 seen |
| Three | 10 | 110 seen |

The match transition is taken only from the 110-seen state when the input is 1. That transition returns to the One state, which is how overlapping matches are kept.

A synchronous, active-low reset returns the machine to Idle and discards any partial match. Because the flag is combinational, a consumer should sample it at the clock edge, while the input is stable.

Top module: `mealy_pattern_det`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the machine enters the Idle state. During every cycle in which `rst_n` is low, `hit` is 0.
- R2: `hit` is 1 in a cycle exactly when the current `din` and the three bits accepted before it, oldest first, are 1, 1, 0, 1, and all three earlier bits were accepted after reset was released. In every other cycle, `hit` is 0.
- R3: Matches overlap. The stream 1101101 raises `hit` on its 4th bit and on its 7th bit.
- R4: `hit` is never 1 in a cycle where `din` is 0. A 110 prefix followed by a 0 returns the machine to Idle without a match.
- R5: Bits accepted before a reset never contribute to a match. The prefix 110, then reset, then 1 gives no `hit`.
- R6: A run of three or more 1s followed by 0 then 1 gives exactly one `hit`, on that final 1.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | 1 | Serial data bit, one per clock |
| hit | output | 1 | Combinational match flag: 1 while `din` completes 1101 |

## Verification
On every cycle, the embedded assertions check four things:
- the forced return to Idle after a reset edge;
- the silent flag while reset is low;
- that a flag is never raised with a 0 on the input;
- that every flag is preceded by the bits 1, 1, 0 and is followed by the One state.

Exact agreement with the last-four-bits definition, overlap spacing, and the discarding of history across a reset are properties of whole streams. Only the bench's scenarios show these: directed sequences, then a long random stream checked against a shift-register model.

// File: rtl/pdet_pkg.sv
// Package: shared state type for the serial pattern detector.
// Assumes a two-bit Gray-coded state; codes are fixed and relied on by
// the next-state and output logic.
package pdet_pkg;
    localparam int unsigned ST_W = 2;

    typedef enum logic [ST_W-1:0] {
        ST_IDLE  = 2'b00,  // last bit 0 or just reset
        ST_ONE   = 2'b01,  // a fresh 1
        ST_TWO   = 2'b11,  // 11 seen
        ST_THREE = 2'b10   // 110 seen
    } pdet_state_e;
endpackage

// File: rtl/pdet_next.sv
// Module: next-state logic of the detector.
// Pure combinational; assumes the state is always one of the four codes.
module pdet_next
    import pdet_pkg::*;
(
    input  pdet_state_e cur_st,
    input  logic        bit_in,
    output pdet_state_e nxt_st
);
    // Transition table of the Mealy machine, overlap kept via THREE->ONE.
    always_comb begin
        unique case (cur_st)
            ST_IDLE:  nxt_st = bit_in ? ST_ONE   : ST_IDLE;
            ST_ONE:   nxt_st = bit_in ? ST_TWO   : ST_IDLE;
            ST_TWO:   nxt_st = bit_in ? ST_TWO   : ST_THREE;
            ST_THREE: nxt_st = bit_in ? ST_ONE   : ST_IDLE;
            default:  nxt_st = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/pdet_out.sv
// Module: Mealy output decode.
// Combinational from state and input; the caller keeps bit_in stable
// around the sampling edge.
module pdet_out
    import pdet_pkg::*;
(
    input  pdet_state_e cur_st,
    input  logic        bit_in,
    input  logic        rst_n,
    output logic        match
);
    // Flag the completing 1 out of the 110-seen state, silenced in reset.
    always_comb begin
        match = rst_n && bit_in && (cur_st == ST_THREE);
    end
endmodule

// File: rtl/pdet_state_reg.sv
// Module: two-bit state register with synchronous active-low reset.
// Assumes rst_n is synchronous to clk.
module pdet_state_reg
    import pdet_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  pdet_state_e nxt_st,
    output pdet_state_e cur_st
);
    logic rst_seen_q;

    // Hold the state; reset returns it to Idle.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_st <= ST_IDLE;
        else        cur_st <= nxt_st;
    end

    // Remember that the last edge was a reset edge, for the check below.
    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
    end

    // R1
    always_comb begin
        if (rst_seen_q == 1'b1) begin
            rst_to_idle_chk: assert (cur_st == ST_IDLE)
                else $error("state not Idle after reset edge");
        end
    end
endmodule

// File: rtl/mealy_pattern_det.sv
// Module: top of the serial 1101 detector (Mealy, overlapping).
// Assumes one bit per clock on din, stable around the rising edge;
// hit is combinational and must be sampled at that edge.
module mealy_pattern_det
    import pdet_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic hit
);
    pdet_state_e st_q;
    pdet_state_e st_d;

    pdet_next u_next (
        .cur_st (st_q),
        .bit_in (din),
        .nxt_st (st_d)
    );

    pdet_state_reg u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .nxt_st (st_d),
        .cur_st (st_q)
    );

    pdet_out u_out (
        .cur_st (st_q),
        .bit_in (din),
        .rst_n  (rst_n),
        .match  (hit)
    );

    // R1
    always_comb begin
        if (rst_n == 1'b0) begin
            quiet_in_reset_chk: assert (hit == 1'b0)
                else $error("hit raised during reset");
        end
    end

    // R4
    zero_in_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !din |-> !hit);

    // R2
    prefix_before_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (!$past(din) && $past(din, 2) && $past(din, 3)));

    // R3
    overlap_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (st_q == ST_ONE));
endmodule

// File: tb/tb_mealy_pattern_det.sv
`timescale 1ns/1ps
module tb_mealy_pattern_det;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic din = 1'b0;
    logic hit;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    bit    exp_q[$];
    string req_q[$];

    logic [2:0] hist = 3'b000;
    int         depth = 0;

    mealy_pattern_det dut (.clk(clk), .rst_n(rst_n), .din(din), .hit(hit));

    always #2.5 clk = ~clk;

    // Driver: apply one bit at a falling edge and push its expected flag.
    task automatic drive_bit(input logic r, input logic b, input string req);
        bit e;
        @(negedge clk);
        rst_n = r;
        din   = b;
        e = r && (depth >= 3) && ({hist, b} == 4'b1101);
        exp_q.push_back(e);
        req_q.push_back(req);
        if (!r) begin
            depth = 0;
            hist  = 3'b000;
        end else begin
            hist  = {hist[1:0], b};
            if (depth < 3) depth++;
        end
    endtask

    task automatic drive_str(input string s, input string req);
        for (int i = 0; i < s.len(); i++)
            drive_bit(1'b1, s[i] == "1", req);
    endtask

    // Monitor: just after each falling edge, compare hit to the oldest item.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                bit    e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                n_total++;
                if (hit !== e) begin
                    n_fail++;
                    $display("FAIL %s: hit=%b expected=%b at %0t", r, hit, e, $time);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #200000;
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: timed out, expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        // R1: reset held with ones on din
        for (int i = 0; i < 4; i++) drive_bit(1'b0, 1'b1, "R1");
        drive_str("1101", "R2");
        drive_str("00", "R2");
        drive_str("1101101", "R3");
        drive_str("0", "R3");
        drive_str("1100", "R4");
        drive_str("110", "R5");
        drive_bit(1'b0, 1'b0, "R5");
        drive_str("1", "R5");
        drive_str("0011101", "R6");
        drive_str("1111101", "R6");
        drive_str("110", "R1");
        drive_bit(1'b0, 1'b1, "R1");
        drive_str("101", "R5");
        for (int i = 0; i < 400; i++)
            drive_bit(1'b1, (i % 11 == 3) ? 1'b0 : 1'($urandom_range(0, 1)), "R2");
        drive_bit(1'b1, 1'b0, "R2");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule